// File: doc/BRIEF.md
# Word-Granular Permission Check Cache

This block sits beside a processor pipeline and rules on every load, store and instruction fetch. Each rule is made against a permission that applies to one aligned 32-bit word. The permissions belong to the protection domain that is currently running. The block keeps a small fully associative cache of permission lines. Each line is tagged with the domain number and the line address. On a hit the verdict is given locally. On a miss the block makes one read from a flat permission table in memory, installs the line and retries the lookup.

The table's location comes from a base-address register. The active domain comes from a domain register. Domain 0 is exempt and is never checked. The top bit of the domain number tells kernel domains from user domains. Writing either register, or pulsing the flush input, empties the cache.

Only one request is in flight at a time. The requester hands in an access and waits on a valid/ready pair for the verdict. The verdict can take many cycles.

Top module: `perm_guard`

## Requirements
- R1: After reset, req_ready is 1, vrd_valid is 0, mem_req_valid is 0, both control registers read as 0 (domain 0) and the cache holds no valid line.
- R2: While the domain register is 0, every access is allowed and no memory read is issued.
- R3: A miss issues exactly one read, at address base + (addr >> 6) * 4. The permission of the word at addr is the 2-bit field at bits [2k+1:2k] of the returned 32-bit word, where k = addr[5:2].
- R4: Access kinds are encoded 00 load, 01 store, 10 fetch, and 11 is always refused. Permission code 00 allows nothing. Code 01 allows load only. Code 10 allows load and store. Code 11 allows load and fetch.
- R5: A later access by the same domain to any word of a cached line is ruled on with no memory read.
- R6: The cache holds 8 lines and replaces them in round-robin order from slot 0. After 9 distinct lines have been filled since the cache was emptied, the first line misses again and the second still hits.
- R7: A write to either control register (cfg_sel 0 = table base, 1 = domain in the low 16 bits), or a flush pulse, empties the cache. The next access to any line then misses.
- R8: When an empty-cache event falls in the same cycle as a memory response, or while a read is outstanding, the returned line is not installed. The block then reads the table again before giving its verdict.
- R9: Each verdict carries the access address and kind. It also carries vrd_kernel, which is 1 when the domain's most significant bit is 0.
- R10: A verdict stays valid and unchanged until vrd_ready is taken, and req_ready stays 0 while a request is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Block can take a request |
| req_addr | input | 32 | Byte address of the access |
| req_kind | input | 2 | 00 load, 01 store, 10 fetch |
| cfg_wr_en | input | 1 | Control register write strobe |
| cfg_sel | input | 1 | 0 table base, 1 domain number |
| cfg_wdata | input | 32 | Control register write data |
| flush | input | 1 | Empty the cache |
| mem_req_valid | output | 1 | Table read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Byte address of the table word |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 32 | Sixteen 2-bit permission codes |
| vrd_valid | output | 1 | Verdict present |
| vrd_ready | input | 1 | Requester takes the verdict |
| vrd_allow | output | 1 | 1 allowed, 0 fault |
| vrd_addr | output | 32 | Address of the judged access |
| vrd_kind | output | 2 | Kind of the judged access |
| vrd_kernel | output | 1 | Domain is kernel mode |

## Verification
Emptying the cache can fall in the same cycle as a table response: a flush pulse, or a register write, may coincide with the fill that response would make. The bench waits until it sees the response valid, then raises flush for exactly that cycle. It judges the result by the verdict and by the count of table reads. A correct block still gives the right verdict, but only after a second read. A block that let the fill win would answer after one read. The random phase also lets register writes fall between accesses, and checks every read count against a bench-side model of the cache.

// File: rtl/perm_pkg.sv
// Shared types and the permission decode for the word permission checker.
// Assumes 2-bit permission codes and 2-bit access kinds.
package perm_pkg;

    localparam int CODE_W = 2;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'b00,
        ACC_STORE = 2'b01,
        ACC_FETCH = 2'b10,
        ACC_RSVD  = 2'b11
    } acc_kind_e;

    typedef enum logic [1:0] {
        PC_NONE  = 2'b00,
        PC_RO    = 2'b01,
        PC_RW    = 2'b10,
        PC_XR    = 2'b11
    } perm_code_e;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_CHECK = 3'd1,
        S_MREQ  = 3'd2,
        S_MWAIT = 3'd3,
        S_RESP  = 3'd4
    } seq_state_e;

    // Decide whether one permission code admits one access kind.
    function automatic logic code_allows(input logic [1:0] code, input logic [1:0] kind);
        logic ok;
        ok = 1'b0;
        case (acc_kind_e'(kind))
            ACC_LOAD:  ok = (perm_code_e'(code) != PC_NONE);
            ACC_STORE: ok = (perm_code_e'(code) == PC_RW);
            ACC_FETCH: ok = (perm_code_e'(code) == PC_XR);
            default:   ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/perm_ctrl_regs.sv
// Control registers: table base address and active domain number.
// Any write, or a flush pulse, raises a one-cycle cache invalidate.
// Assumes the table base is word aligned; the low two bits are forced to zero.
module perm_ctrl_regs #(
    parameter int ADDR_W = 32,
    parameter int DOM_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic              cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              flush,
    output logic [ADDR_W-1:0] base_q,
    output logic [DOM_W-1:0]  dom_q,
    output logic              inval
);

    // Register updates for the base and domain registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            dom_q  <= '0;
        end else if (cfg_wr_en) begin
            if (cfg_sel) dom_q  <= cfg_wdata[DOM_W-1:0];
            else         base_q <= {cfg_wdata[ADDR_W-1:2], 2'b00};
        end
    end

    // Invalidate request for the cache in the same cycle as the write or flush.
    always_comb begin
        inval = cfg_wr_en | flush;
    end

endmodule

// File: rtl/perm_tag_store.sv
// Fully associative store of permission lines tagged by domain and line address.
// Fills go to a round-robin slot. An invalidate wins over a fill in the same cycle.
// Assumes the sequencer never fills a line that already hits.
module perm_tag_store #(
    parameter int ENTRIES = 8,
    parameter int DOM_W   = 16,
    parameter int LINE_W  = 26,
    parameter int DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [DOM_W-1:0]   lk_dom,
    input  logic [LINE_W-1:0]  lk_line,
    input  logic               fill_en,
    input  logic [DOM_W-1:0]   fill_dom,
    input  logic [LINE_W-1:0]  fill_line,
    input  logic [DATA_W-1:0]  fill_data,
    input  logic               inval,
    output logic               hit,
    output logic [DATA_W-1:0]  hit_data,
    output logic [ENTRIES-1:0] hit_vec,
    output logic [ENTRIES-1:0] valid_vec
);

    localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(ENTRIES - 1);

    logic [DOM_W-1:0]  tag_dom  [ENTRIES];
    logic [LINE_W-1:0] tag_line [ENTRIES];
    logic [DATA_W-1:0] line_dat [ENTRIES];
    logic [PTR_W-1:0]  rr_ptr;

    genvar gi;
    generate
        for (gi = 0; gi < ENTRIES; gi++) begin : g_slot
            // Tag comparison for one slot.
            always_comb begin
                hit_vec[gi] = valid_vec[gi] && (tag_dom[gi] == lk_dom) && (tag_line[gi] == lk_line);
            end

            // Slot state: cleared on invalidate, written when chosen for a fill.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    valid_vec[gi] <= 1'b0;
                    tag_dom[gi]   <= '0;
                    tag_line[gi]  <= '0;
                    line_dat[gi]  <= '0;
                end else if (inval) begin
                    valid_vec[gi] <= 1'b0;
                end else if (fill_en && (rr_ptr == PTR_W'(gi))) begin
                    valid_vec[gi] <= 1'b1;
                    tag_dom[gi]   <= fill_dom;
                    tag_line[gi]  <= fill_line;
                    line_dat[gi]  <= fill_data;
                end
            end
        end
    endgenerate

    // Merge of the matching slot's data.
    always_comb begin
        hit      = |hit_vec;
        hit_data = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (hit_vec[i]) hit_data = hit_data | line_dat[i];
        end
    end

    // Round-robin victim pointer: restarts at slot 0 when the cache is emptied.
    always_ff @(posedge clk) begin
        if (!rst_n || inval) begin
            rr_ptr <= '0;
        end else if (fill_en) begin
            rr_ptr <= (rr_ptr == LAST) ? '0 : rr_ptr + 1'b1;
        end
    end

endmodule

// File: rtl/perm_seq.sv
// Request sequencer: accepts one access, looks it up, fetches a table line on a miss,
// retries, and holds the verdict until it is taken.
// Assumes one outstanding memory read and that memory answers every accepted read.
module perm_seq
    import perm_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DOM_W  = 16,
    parameter int DATA_W = 32,
    parameter int OFS_W  = 6,
    parameter int LINE_W = ADDR_W - OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_kind,
    input  logic [ADDR_W-1:0] base_q,
    input  logic [DOM_W-1:0]  dom_q,
    input  logic              inval,
    input  logic              hit,
    input  logic [DATA_W-1:0] hit_data,
    output logic [LINE_W-1:0] cur_line,
    output logic              fill_en,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    output logic              vrd_valid,
    input  logic              vrd_ready,
    output logic              vrd_allow,
    output logic [ADDR_W-1:0] vrd_addr,
    output logic [1:0]        vrd_kind,
    output logic              vrd_kernel
);

    localparam int SEL_W = OFS_W - 2;

    seq_state_e        state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [1:0]        kind_q;
    logic              stale_q;
    logic              allow_q;
    logic              kernel_q;
    logic [SEL_W-1:0]  word_sel;
    logic [1:0]        code;
    logic              bypass;

    // Decode of the held request.
    always_comb begin
        cur_line = addr_q[ADDR_W-1:OFS_W];
        word_sel = addr_q[OFS_W-1:2];
        code     = 2'(hit_data >> {word_sel, 1'b0});
        bypass   = (dom_q == '0);
    end

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        case (state_q)
            S_IDLE:  if (req_valid) state_d = S_CHECK;
            S_CHECK: state_d = (bypass || hit) ? S_RESP : S_MREQ;
            S_MREQ:  if (mem_req_ready) state_d = S_MWAIT;
            S_MWAIT: if (mem_rsp_valid) state_d = S_CHECK;
            S_RESP:  if (vrd_ready) state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Capture of the accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            kind_q <= '0;
        end else if (state_q == S_IDLE && req_valid) begin
            addr_q <= req_addr;
            kind_q <= req_kind;
        end
    end

    // Marks a read whose data must not be installed because the cache was emptied.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stale_q <= 1'b0;
        end else if (state_q == S_MWAIT && mem_rsp_valid) begin
            stale_q <= 1'b0;
        end else if (inval && (state_q == S_MREQ || state_q == S_MWAIT)) begin
            stale_q <= 1'b1;
        end
    end

    // Verdict capture at the end of a successful lookup.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            allow_q  <= 1'b0;
            kernel_q <= 1'b0;
        end else if (state_q == S_CHECK && (bypass || hit)) begin
            allow_q  <= bypass ? 1'b1 : code_allows(code, kind_q);
            kernel_q <= ~dom_q[DOM_W-1];
        end
    end

    // Handshake and memory outputs.
    always_comb begin
        req_ready     = (state_q == S_IDLE);
        mem_req_valid = (state_q == S_MREQ);
        mem_req_addr  = base_q + {{(ADDR_W-LINE_W-2){1'b0}}, cur_line, 2'b00};
        fill_en       = (state_q == S_MWAIT) && mem_rsp_valid && !stale_q && !inval;
        vrd_valid     = (state_q == S_RESP);
        vrd_allow     = allow_q;
        vrd_addr      = addr_q;
        vrd_kind      = kind_q;
        vrd_kernel    = kernel_q;
    end

endmodule

// File: rtl/perm_guard.sv
// Top level of the word permission checker: control registers, tag store and
// request sequencer. Assumes a 32-bit table read holds the codes of 16 words.
module perm_guard #(
    parameter int ADDR_W  = 32,
    parameter int DOM_W   = 16,
    parameter int DATA_W  = 32,
    parameter int ENTRIES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_kind,
    input  logic              cfg_wr_en,
    input  logic              cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              flush,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data,
    output logic              vrd_valid,
    input  logic              vrd_ready,
    output logic              vrd_allow,
    output logic [ADDR_W-1:0] vrd_addr,
    output logic [1:0]        vrd_kind,
    output logic              vrd_kernel
);

    localparam int WORDS_PER_LINE = DATA_W / perm_pkg::CODE_W;
    localparam int OFS_W          = $clog2(WORDS_PER_LINE) + 2;
    localparam int LINE_W         = ADDR_W - OFS_W;

    logic [ADDR_W-1:0]  base_q;
    logic [DOM_W-1:0]   dom_q;
    logic               inval;
    logic               hit;
    logic [DATA_W-1:0]  hit_data;
    logic [ENTRIES-1:0] hit_vec;
    logic [ENTRIES-1:0] valid_vec;
    logic [LINE_W-1:0]  cur_line;
    logic               fill_en;

    perm_ctrl_regs #(.ADDR_W(ADDR_W), .DOM_W(DOM_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .flush(flush), .base_q(base_q), .dom_q(dom_q),
        .inval(inval)
    );

    perm_tag_store #(.ENTRIES(ENTRIES), .DOM_W(DOM_W), .LINE_W(LINE_W), .DATA_W(DATA_W)) u_tags (
        .clk(clk), .rst_n(rst_n), .lk_dom(dom_q), .lk_line(cur_line),
        .fill_en(fill_en), .fill_dom(dom_q), .fill_line(cur_line),
        .fill_data(mem_rsp_data), .inval(inval), .hit(hit), .hit_data(hit_data),
        .hit_vec(hit_vec), .valid_vec(valid_vec)
    );

    perm_seq #(.ADDR_W(ADDR_W), .DOM_W(DOM_W), .DATA_W(DATA_W), .OFS_W(OFS_W), .LINE_W(LINE_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_kind(req_kind), .base_q(base_q), .dom_q(dom_q),
        .inval(inval), .hit(hit), .hit_data(hit_data), .cur_line(cur_line),
        .fill_en(fill_en), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .vrd_valid(vrd_valid), .vrd_ready(vrd_ready), .vrd_allow(vrd_allow),
        .vrd_addr(vrd_addr), .vrd_kind(vrd_kind), .vrd_kernel(vrd_kernel)
    );

endmodule

// File: rtl/perm_guard_chk.sv
// Assertion checker for perm_guard, attached by bind. Observes handshakes,
// cache occupancy and the invalidate path.
module perm_guard_chk #(
    parameter int ADDR_W  = 32,
    parameter int ENTRIES = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              vrd_valid,
    input logic              vrd_ready,
    input logic              vrd_allow,
    input logic [ADDR_W-1:0] vrd_addr,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic              inval,
    input logic              fill_en,
    input logic [ENTRIES-1:0] hit_vec,
    input logic [ENTRIES-1:0] valid_vec
);

    // R10: no new request is taken while a verdict is pending.
    p_one_outstanding_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_ready && vrd_valid));

    // R10: a verdict not yet taken stays put.
    p_verdict_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        vrd_valid && !vrd_ready |=> vrd_valid && $stable(vrd_allow) && $stable(vrd_addr));

    // R3: a table read not yet accepted keeps its address.
    p_mreq_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

    // R7: an invalidate leaves no valid line behind.
    p_flush_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        inval |=> valid_vec == '0);

    // R8: a fill coinciding with an invalidate installs nothing.
    p_fill_loses_r8: assert property (@(posedge clk) disable iff (!rst_n)
        inval && !fill_en |=> $countones(valid_vec) == 0);

    // R5: a lookup matches at most one slot.
    p_single_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

endmodule

bind perm_guard perm_guard_chk #(.ADDR_W(ADDR_W), .ENTRIES(ENTRIES)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .vrd_valid(vrd_valid),
    .vrd_ready(vrd_ready), .vrd_allow(vrd_allow), .vrd_addr(vrd_addr),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .inval(inval), .fill_en(fill_en),
    .hit_vec(hit_vec), .valid_vec(valid_vec)
);

// File: tb/test_perm_guard.sv
// Bench for perm_guard: directed corner cases plus seeded random accesses,
// checked against a requirement-level model of the table and the cache.
module test_perm_guard;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_kind = '0;
    logic        cfg_wr_en = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        flush = 1'b0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b1;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        vrd_valid;
    logic        vrd_ready = 1'b1;
    logic        vrd_allow;
    logic [31:0] vrd_addr;
    logic [1:0]  vrd_kind;
    logic        vrd_kernel;

    int errors = 0;
    int checks = 0;
    int reads  = 0;

    logic [31:0] cur_base = '0;
    logic [15:0] cur_dom  = '0;
    logic [25:0] m_line [8];
    logic        m_vld  [8];
    int          m_ptr = 0;

    always #4 clk = ~clk;

    perm_guard i_perm_guard (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_kind(req_kind), .cfg_wr_en(cfg_wr_en),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .flush(flush),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .vrd_valid(vrd_valid), .vrd_ready(vrd_ready),
        .vrd_allow(vrd_allow), .vrd_addr(vrd_addr), .vrd_kind(vrd_kind),
        .vrd_kernel(vrd_kernel)
    );

    // Table contents as a function of the byte address of each table word.
    function automatic logic [31:0] tbl_word(input logic [31:0] a);
        return (a * 32'h9E37_79B1) ^ (a >> 7) ^ 32'h5A3C_0F96;
    endfunction

    function automatic logic [31:0] tbl_addr(input logic [31:0] base, input logic [31:0] addr);
        return base + ((addr >> 6) << 2);
    endfunction

    function automatic logic exp_allow(input logic [31:0] base, input logic [15:0] dom,
                                       input logic [31:0] addr, input logic [1:0] kind);
        logic [1:0] c;
        if (dom == 16'd0) return 1'b1;
        c = 2'(tbl_word(tbl_addr(base, addr)) >> (2 * addr[5:2]));
        case (kind)
            2'b00: return c != 2'b00;
            2'b01: return c == 2'b10;
            2'b10: return c == 2'b11;
            default: return 1'b0;
        endcase
    endfunction

    // Memory model: fixed latency, counts accepted reads.
    logic        pend = 1'b0;
    logic [1:0]  lat = '0;
    logic [31:0] paddr = '0;
    always @(posedge clk) begin
        mem_rsp_valid <= 1'b0;
        if (mem_req_valid && mem_req_ready) begin
            pend  <= 1'b1;
            lat   <= 2'd1;
            paddr <= mem_req_addr;
            reads <= reads + 1;
        end else if (pend) begin
            if (lat == 0) begin
                mem_rsp_valid <= 1'b1;
                mem_rsp_data  <= tbl_word(paddr);
                pend <= 1'b0;
            end else begin
                lat <= lat - 1'b1;
            end
        end
    end

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < 8; i++) m_vld[i] = 1'b0;
        m_ptr = 0;
    endtask

    // Expected number of table reads for one access; updates the model.
    function automatic int model_access(input logic [31:0] addr);
        if (cur_dom == 16'd0) return 0;
        for (int i = 0; i < 8; i++) if (m_vld[i] && m_line[i] == addr[31:6]) return 0;
        m_vld[m_ptr] = 1'b1;
        m_line[m_ptr] = addr[31:6];
        m_ptr = (m_ptr + 1) % 8;
        return 1;
    endfunction

    task automatic cfg_write(input logic sel, input logic [31:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        if (sel) cur_dom = d[15:0]; else cur_base = {d[31:2], 2'b00};
        model_clear();
    endtask

    // One access with full verdict and read-count checking.
    task automatic access(input logic [31:0] addr, input logic [1:0] kind, input string req,
                          input int exp_reads);
        int r0;
        @(negedge clk);
        r0 = reads;
        req_valid = 1'b1; req_addr = addr; req_kind = kind;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        while (!vrd_valid) @(negedge clk);
        chk(vrd_allow == exp_allow(cur_base, cur_dom, addr, kind), req, 32'(vrd_allow),
            32'(exp_allow(cur_base, cur_dom, addr, kind)));
        chk(vrd_addr == addr && vrd_kind == kind, "R9 addr/kind", vrd_addr, addr);
        chk(vrd_kernel == ~cur_dom[15], "R9 kernel", 32'(vrd_kernel), 32'(~cur_dom[15]));
        chk(reads - r0 == exp_reads, {req, " reads"}, 32'(reads - r0), 32'(exp_reads));
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        model_clear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(req_ready && !vrd_valid && !mem_req_valid, "R1 reset outputs",
            {29'd0, req_ready, vrd_valid, mem_req_valid}, 32'h4);

        // R2: domain 0 bypass, no reads
        access(32'h0000_1234, 2'b01, "R2 bypass store", 0);
        access(32'hFFFF_FF00, 2'b10, "R2 bypass fetch", 0);

        // R3/R4: miss then hits within one line, each kind
        cfg_write(1'b0, 32'h0010_0000);
        cfg_write(1'b1, 32'h0000_0005);
        access(32'h0000_2040, 2'b00, "R3 miss load", model_access(32'h0000_2040));
        access(32'h0000_2044, 2'b01, "R4 store", model_access(32'h0000_2044));
        access(32'h0000_2048, 2'b10, "R4 fetch", model_access(32'h0000_2048));
        access(32'h0000_207C, 2'b11, "R4 reserved kind", model_access(32'h0000_207C));
        access(32'h0000_2050, 2'b00, "R5 hit", model_access(32'h0000_2050));

        // R9: user domain
        cfg_write(1'b1, 32'h0000_8003);
        access(32'h0000_3000, 2'b00, "R9 user domain", model_access(32'h0000_3000));

        // R7: flush empties the cache
        @(negedge clk); flush = 1'b1; @(negedge clk); flush = 1'b0; model_clear();
        access(32'h0000_3004, 2'b01, "R7 miss after flush", model_access(32'h0000_3004));

        // R6: round-robin replacement
        cfg_write(1'b1, 32'h0000_0007);
        for (int i = 0; i < 9; i++)
            access(32'h0004_0000 + 32'(i) * 64, 2'b00, "R6 fill", 1);
        for (int i = 0; i < 9; i++) void'(model_access(32'h0004_0000 + 32'(i) * 64));
        access(32'h0004_0040, 2'b00, "R6 second line still hits", 0);
        access(32'h0004_0000, 2'b00, "R6 first line evicted", 1);
        void'(model_access(32'h0004_0000));

        // R8: flush coinciding with the table response
        begin
            int r0;
            cfg_write(1'b1, 32'h0000_0009);
            @(negedge clk);
            r0 = reads;
            req_valid = 1'b1; req_addr = 32'h0008_0010; req_kind = 2'b00;
            @(negedge clk);
            req_valid = 1'b0;
            while (!mem_rsp_valid) @(negedge clk);
            flush = 1'b1;
            @(negedge clk);
            flush = 1'b0;
            while (!vrd_valid) @(negedge clk);
            chk(reads - r0 == 2, "R8 refetch after collision", 32'(reads - r0), 32'd2);
            chk(vrd_allow == exp_allow(cur_base, cur_dom, 32'h0008_0010, 2'b00), "R8 verdict",
                32'(vrd_allow), 32'(exp_allow(cur_base, cur_dom, 32'h0008_0010, 2'b00)));
            @(negedge clk);
            model_clear();
            void'(model_access(32'h0008_0010));
        end

        // R10: verdict held while not taken
        vrd_ready = 1'b0;
        @(negedge clk);
        req_valid = 1'b1; req_addr = 32'h0008_0014; req_kind = 2'b00;
        @(negedge clk);
        req_valid = 1'b0;
        while (!vrd_valid) @(negedge clk);
        repeat (3) begin
            @(negedge clk);
            chk(vrd_valid && !req_ready && vrd_addr == 32'h0008_0014, "R10 hold",
                {30'd0, vrd_valid, req_ready}, 32'h2);
        end
        vrd_ready = 1'b1;
        @(negedge clk);
        chk(req_ready && !vrd_valid, "R10 release", {30'd0, req_ready, vrd_valid}, 32'h2);

        // Random phase
        for (int n = 0; n < 300; n++) begin
            logic [31:0] a;
            int sel;
            sel = int'($urandom % 20);
            if (sel == 0) cfg_write(1'b1, ($urandom % 3 == 0) ? 32'h0 :
                                    (($urandom % 2 == 0) ? 32'h0000_0005 : 32'h0000_8003));
            else if (sel == 1) cfg_write(1'b0, 32'h0020_0000 + (($urandom % 4) << 8));
            a = 32'h0001_0000 + (($urandom % 12) << 6) + (($urandom % 16) << 2);
            access(a, 2'($urandom % 3), "R4 random", model_access(a));
        end

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule